// File: doc/BRIEF.md
# PWM Control-Input Acceptance and Termination

This block conditions one external control input of a PWM generator, such as a fault or current-limit line. It produces a single active-high "control asserted" level that the PWM output stage uses to override or cut its drive. The raw input can be inverted, resampled only at the end of each PWM cycle, and gated by an acceptance qualifier. It is accepted as a level, as a one-cycle edge pulse, or through a set/reset latch. A latch stays set until a selectable termination event occurs. That event is itself gated by a termination qualifier and can be applied at once or deferred to the next end-of-cycle strobe.

Qualifiers are picked from a small set of generator-local signals: duty-active, blanking-active, generator-triggered, and three external sources. They can also be replaced by a software level bit. A bypass path ignores all of the local logic and instead ORs the outputs of other generators chosen by a mask. The block's own index is always excluded from that mask.

The output is registered: it reflects the inputs sampled at the preceding rising clock edge. All state clears on a synchronous active-high reset.

Top module: `pwm_ctl_gate`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ctl_asserted` is 0. Reset also clears any held latch, the end-of-cycle sample and any pending termination.
- R2: With `acc_mode`=000 (level), `ctl_asserted` equals the polarity-adjusted input (`ctl_in` XOR `in_inv`) AND the acceptance qualifier, one clock later.
- R3: With `acc_mode`=001, the output is a one-cycle pulse on a 0-to-1 change of the adjusted input. With 010, it is a one-cycle pulse on either change.
- R4: Codes 011, 100 and 101 set a latch from, respectively, the adjusted input's level, its rising edge, or either edge. The output then stays high until termination, qualified by the acceptance qualifier.
- R5: Codes 110 and 111 act as 100 and 101, but the acceptance-qualifier signal sets the latch and the adjusted control input gates the output.
- R6: When set and clear coincide, `latch_rst_dom`=0 leaves the latch set, and `latch_rst_dom`=1 leaves it clear.
- R7: `term_sel` picks the termination event as follows. 000 is the `sw_term_pulse` strobe. 001 is the primary input changing from active to inactive. 010, 011 and 100 are `trig_evt[0]`, `[1]` and `[2]`. 101, 110 and 111 are `ext_src[0]`, `[1]` and `[2]`. `term_inv` inverts only the 101–111 sources.
- R8: A termination event acts only while the termination qualifier is 1. `tq_src` 000 and 111 force that qualifier to 1, and `tq_inv` has no effect on them. Codes 001–110 select, in order, `duty_act`, `blank_act`, `pg_trig`, and `ext_src[0]` to `ext_src[2]`, each XOR `tq_inv`.
- R9: With `term_sync_dis`=0, a qualified termination is held pending and clears the latch at the next cycle with `eoc`=1. With `term_sync_dis`=1, the clear happens in the cycle of the event.
- R10: With `in_sync`=1, the adjusted input is captured only in cycles with `eoc`=1, and the held copy is used in its place.
- R11: The acceptance qualifier is chosen by `aq_src` with the same 001–110 order as R8, XOR `aq_inv`. Code 000 forces it to 1 and code 111 forces it to 0. `aq_inv` is ignored for 000 and 111.
- R12: `sw_level` is ORed into one place chosen by `sw_route`: 00 into the control input (before inversion), 01 into the acceptance qualifier, 10 into the termination qualifier. Code 11 routes it nowhere.
- R13: With `byp_en`=1, the output one clock later is the OR of `peer_out[i]` AND `byp_mask[i]` over every index except `SELF_IDX`. The local logic has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_in | input | 1 | Selected external control input |
| duty_act | input | 1 | Base PWM duty-active signal |
| blank_act | input | 1 | Leading-edge blanking active |
| pg_trig | input | 1 | Generator-triggered status |
| ext_src | input | 3 | Three further external sources |
| trig_evt | input | 3 | Trigger events A, B, C (bits 0, 1, 2) |
| eoc | input | 1 | End-of-PWM-cycle strobe |
| acc_mode | input | 3 | Acceptance mode |
| latch_rst_dom | input | 1 | 1: clear wins in the latch |
| term_sel | input | 3 | Termination event select |
| term_inv | input | 1 | Invert external termination sources |
| term_sync_dis | input | 1 | 1: clear immediately, 0: at end of cycle |
| in_sync | input | 1 | Sample control input only at end of cycle |
| in_inv | input | 1 | Invert control input |
| aq_src | input | 3 | Acceptance qualifier source |
| aq_inv | input | 1 | Invert acceptance qualifier |
| tq_src | input | 3 | Termination qualifier source |
| tq_inv | input | 1 | Invert termination qualifier |
| sw_level | input | 1 | Software level bit |
| sw_route | input | 2 | Software level destination |
| sw_term_pulse | input | 1 | One-cycle software termination strobe |
| byp_en | input | 1 | Use the bypass OR of other generators |
| byp_mask | input | NGEN | Bypass source mask |
| peer_out | input | NGEN | Outputs of all generators' logic |
| ctl_asserted | output | 1 | Registered control-asserted level |

## Verification
The acceptance modes are driven with a held-high input, a single low-high-low pulse and a high-to-low step. This separates level following from rising-only pulses, both-edge pulses and latched holds. A mode-100 run with the input kept high after a clear shows that a held level does not re-set an edge latch. The swapped modes are driven with edges on the qualifier alone and then on the control input alone, which shows which signal sets and which gates. Termination is applied with the right and wrong trigger, with the qualifier low and high, with forced qualifiers under inversion, and with a coincident set. An end-of-cycle strobe a few cycles after the event separates an immediate clear from a deferred one.

// File: rtl/pwmgate_pkg.sv
package pwmgate_pkg;
  localparam int NUM_EXT  = 3;
  localparam int NUM_TRIG = 3;

  typedef enum logic [2:0] {
    ACC_LEVEL  = 3'b000,
    ACC_RISE   = 3'b001,
    ACC_ANY    = 3'b010,
    ACC_LATCH  = 3'b011,
    ACC_LRISE  = 3'b100,
    ACC_LANY   = 3'b101,
    ACC_QLRISE = 3'b110,
    ACC_QLANY  = 3'b111
  } acc_mode_e;

  typedef enum logic [2:0] {
    TRM_SW   = 3'b000,
    TRM_AUTO = 3'b001,
    TRM_TRGA = 3'b010,
    TRM_TRGB = 3'b011,
    TRM_TRGC = 3'b100,
    TRM_EXT0 = 3'b101,
    TRM_EXT1 = 3'b110,
    TRM_EXT2 = 3'b111
  } term_sel_e;

  typedef enum logic [1:0] {
    SWR_CTL  = 2'b00,
    SWR_AQ   = 2'b01,
    SWR_TQ   = 2'b10,
    SWR_NONE = 2'b11
  } sw_route_e;

  localparam logic [2:0] QSRC_ONE  = 3'b000;
  localparam logic [2:0] QSRC_SOFT = 3'b111;
endpackage

// File: rtl/pwmgate_front.sv
module pwmgate_front
  import pwmgate_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_in,
  input  logic               in_inv,
  input  logic               in_sync,
  input  logic               eoc,
  input  logic               duty_act,
  input  logic               blank_act,
  input  logic               pg_trig,
  input  logic [NUM_EXT-1:0] ext_src,
  input  logic [2:0]         aq_src,
  input  logic               aq_inv,
  input  logic [2:0]         tq_src,
  input  logic               tq_inv,
  input  logic               sw_level,
  input  logic [1:0]         sw_route,
  output logic               ctl_eff,
  output logic               aq_val,
  output logic               tq_val
);
  logic ctl_pol;
  logic samp_q;

  // Shared source order for both qualifier selectors (codes 1..6)
  function automatic logic q_pick(input logic [2:0] code, input logic d,
                                  input logic b, input logic t,
                                  input logic [NUM_EXT-1:0] e);
    case (code)
      3'd1:    q_pick = d;
      3'd2:    q_pick = b;
      3'd3:    q_pick = t;
      3'd4:    q_pick = e[0];
      3'd5:    q_pick = e[1];
      3'd6:    q_pick = e[2];
      default: q_pick = 1'b0;
    endcase
  endfunction

  assign ctl_pol = (ctl_in | ((sw_route == SWR_CTL) & sw_level)) ^ in_inv;

  always_ff @(posedge clk) begin
    if (rst)      samp_q <= 1'b0;
    else if (eoc) samp_q <= ctl_pol;
  end

  assign ctl_eff = in_sync ? samp_q : ctl_pol;

  always_comb begin
    if (aq_src == QSRC_ONE)       aq_val = 1'b1;
    else if (aq_src == QSRC_SOFT) aq_val = 1'b0;
    else aq_val = q_pick(aq_src, duty_act, blank_act, pg_trig, ext_src) ^ aq_inv;
    aq_val = aq_val | ((sw_route == SWR_AQ) & sw_level);
  end

  always_comb begin
    if (tq_src == QSRC_ONE || tq_src == QSRC_SOFT) tq_val = 1'b1;
    else tq_val = q_pick(tq_src, duty_act, blank_act, pg_trig, ext_src) ^ tq_inv;
    tq_val = tq_val | ((sw_route == SWR_TQ) & sw_level);
  end
endmodule

// File: rtl/pwmgate_term.sv
module pwmgate_term
  import pwmgate_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          term_sel,
  input  logic                sw_term_pulse,
  input  logic                prim_fall,
  input  logic [NUM_TRIG-1:0] trig_evt,
  input  logic [NUM_EXT-1:0]  ext_src,
  input  logic                term_inv,
  input  logic                tq_val,
  input  logic                term_sync_dis,
  input  logic                eoc,
  output logic                clr
);
  logic src;
  logic term_ok;
  logic pend_q;

  always_comb begin
    case (term_sel)
      TRM_SW:   src = sw_term_pulse;
      TRM_AUTO: src = prim_fall;
      TRM_TRGA: src = trig_evt[0];
      TRM_TRGB: src = trig_evt[1];
      TRM_TRGC: src = trig_evt[2];
      TRM_EXT0: src = ext_src[0] ^ term_inv;
      TRM_EXT1: src = ext_src[1] ^ term_inv;
      default:  src = ext_src[2] ^ term_inv;
    endcase
  end

  assign term_ok = src & tq_val;

  always_ff @(posedge clk) begin
    if (rst)                          pend_q <= 1'b0;
    else if (eoc)                     pend_q <= 1'b0;
    else if (term_ok && !term_sync_dis) pend_q <= 1'b1;
  end

  assign clr = term_sync_dis ? term_ok : (eoc & (pend_q | term_ok));
endmodule

// File: rtl/pwmgate_accept.sv
module pwmgate_accept
  import pwmgate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] acc_mode,
  input  logic       ctl_eff,
  input  logic       aq_val,
  input  logic       clr,
  input  logic       latch_rst_dom,
  output logic       prim_fall,
  output logic       acc
);
  logic swap, prim, qual, prev_q;
  logic rise, anye, set_c;
  logic latch_q, latch_nxt, acc_raw;

  assign swap = (acc_mode == ACC_QLRISE) || (acc_mode == ACC_QLANY);
  assign prim = swap ? aq_val  : ctl_eff;
  assign qual = swap ? ctl_eff : aq_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= prim;
      latch_q <= latch_nxt;
    end
  end

  assign rise      = prim & ~prev_q;
  assign anye      = prim ^ prev_q;
  assign prim_fall = ~prim & prev_q;

  always_comb begin
    case (acc_mode)
      ACC_LATCH:              set_c = prim;
      ACC_LRISE, ACC_QLRISE:  set_c = rise;
      ACC_LANY, ACC_QLANY:    set_c = anye;
      default:                set_c = 1'b0;
    endcase
    if (set_c && clr)  latch_nxt = ~latch_rst_dom;
    else if (set_c)    latch_nxt = 1'b1;
    else if (clr)      latch_nxt = 1'b0;
    else               latch_nxt = latch_q;
    case (acc_mode)
      ACC_LEVEL: acc_raw = prim;
      ACC_RISE:  acc_raw = rise;
      ACC_ANY:   acc_raw = anye;
      default:   acc_raw = latch_nxt;
    endcase
  end

  assign acc = acc_raw & qual;
endmodule

// File: rtl/pwm_ctl_gate.sv
module pwm_ctl_gate
  import pwmgate_pkg::*;
#(
  parameter int NGEN     = 8,
  parameter int SELF_IDX = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_in,
  input  logic                duty_act,
  input  logic                blank_act,
  input  logic                pg_trig,
  input  logic [NUM_EXT-1:0]  ext_src,
  input  logic [NUM_TRIG-1:0] trig_evt,
  input  logic                eoc,
  input  logic [2:0]          acc_mode,
  input  logic                latch_rst_dom,
  input  logic [2:0]          term_sel,
  input  logic                term_inv,
  input  logic                term_sync_dis,
  input  logic                in_sync,
  input  logic                in_inv,
  input  logic [2:0]          aq_src,
  input  logic                aq_inv,
  input  logic [2:0]          tq_src,
  input  logic                tq_inv,
  input  logic                sw_level,
  input  logic [1:0]          sw_route,
  input  logic                sw_term_pulse,
  input  logic                byp_en,
  input  logic [NGEN-1:0]     byp_mask,
  input  logic [NGEN-1:0]     peer_out,
  output logic                ctl_asserted
);
  localparam logic [NGEN-1:0] SELF_MASK = {{(NGEN-1){1'b0}}, 1'b1} << SELF_IDX;

  logic ctl_eff, aq_val, tq_val, prim_fall, clr, acc, byp_or;

  pwmgate_front u_front (
    .clk(clk), .rst(rst), .ctl_in(ctl_in), .in_inv(in_inv), .in_sync(in_sync),
    .eoc(eoc), .duty_act(duty_act), .blank_act(blank_act), .pg_trig(pg_trig),
    .ext_src(ext_src), .aq_src(aq_src), .aq_inv(aq_inv), .tq_src(tq_src),
    .tq_inv(tq_inv), .sw_level(sw_level), .sw_route(sw_route),
    .ctl_eff(ctl_eff), .aq_val(aq_val), .tq_val(tq_val)
  );

  pwmgate_term u_term (
    .clk(clk), .rst(rst), .term_sel(term_sel), .sw_term_pulse(sw_term_pulse),
    .prim_fall(prim_fall), .trig_evt(trig_evt), .ext_src(ext_src),
    .term_inv(term_inv), .tq_val(tq_val), .term_sync_dis(term_sync_dis),
    .eoc(eoc), .clr(clr)
  );

  pwmgate_accept u_accept (
    .clk(clk), .rst(rst), .acc_mode(acc_mode), .ctl_eff(ctl_eff),
    .aq_val(aq_val), .clr(clr), .latch_rst_dom(latch_rst_dom),
    .prim_fall(prim_fall), .acc(acc)
  );

  assign byp_or = |(peer_out & byp_mask & ~SELF_MASK);

  always_ff @(posedge clk) begin
    if (rst) ctl_asserted <= 1'b0;
    else     ctl_asserted <= byp_en ? byp_or : acc;
  end
endmodule

// File: rtl/pwm_ctl_gate_chk.sv
module pwm_ctl_gate_chk #(
  parameter int NGEN     = 8,
  parameter int SELF_IDX = 0
) (
  input logic            clk,
  input logic            rst,
  input logic            ctl_in,
  input logic [2:0]      acc_mode,
  input logic [2:0]      term_sel,
  input logic            term_sync_dis,
  input logic            in_sync,
  input logic            in_inv,
  input logic [2:0]      aq_src,
  input logic [1:0]      sw_route,
  input logic            sw_term_pulse,
  input logic            byp_en,
  input logic [NGEN-1:0] byp_mask,
  input logic [NGEN-1:0] peer_out,
  input logic            ctl_asserted
);
  localparam logic [NGEN-1:0] OWN_BIT = {{(NGEN-1){1'b0}}, 1'b1} << SELF_IDX;

  logic plain_level, rise_mode, hold_mode;
  assign plain_level = !byp_en && acc_mode == 3'b000 && aq_src == 3'b000 &&
                       !in_sync && !in_inv && sw_route == 2'b11;
  assign rise_mode   = !byp_en && acc_mode == 3'b001;
  assign hold_mode   = !byp_en && acc_mode == 3'b011 && aq_src == 3'b000 &&
                       sw_route == 2'b11 && term_sel == 3'b000 &&
                       !sw_term_pulse && term_sync_dis;

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    plain_level |=> ctl_asserted == $past(ctl_in)); // R2

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (rise_mode && ctl_asserted && $past(rise_mode)) |=> !ctl_asserted); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hold_mode && ctl_asserted && $past(hold_mode)) |=> ctl_asserted); // R4

  AST_BYPASS_OR: assert property (@(posedge clk) disable iff (rst)
    byp_en |=> ctl_asserted == $past(|(peer_out & byp_mask & ~OWN_BIT))); // R13

  AST_BYPASS_NOSELF: assert property (@(posedge clk) disable iff (rst)
    (byp_en && (peer_out & ~OWN_BIT) == '0) |=> !ctl_asserted); // R13
endmodule

bind pwm_ctl_gate pwm_ctl_gate_chk #(.NGEN(NGEN), .SELF_IDX(SELF_IDX)) u_chk (
  .clk(clk), .rst(rst), .ctl_in(ctl_in), .acc_mode(acc_mode),
  .term_sel(term_sel), .term_sync_dis(term_sync_dis), .in_sync(in_sync),
  .in_inv(in_inv), .aq_src(aq_src), .sw_route(sw_route),
  .sw_term_pulse(sw_term_pulse), .byp_en(byp_en), .byp_mask(byp_mask),
  .peer_out(peer_out), .ctl_asserted(ctl_asserted)
);

// File: tb/tb_pwm_ctl_gate.sv
`timescale 1ns/1ps
module tb_pwm_ctl_gate;
  localparam int NGEN = 8;

  logic clk = 1'b0;
  logic rst, ctl_in, duty_act, blank_act, pg_trig, eoc;
  logic [2:0] ext_src, trig_evt, acc_mode, term_sel, aq_src, tq_src;
  logic latch_rst_dom, term_inv, term_sync_dis, in_sync, in_inv, aq_inv, tq_inv;
  logic sw_level, sw_term_pulse, byp_en;
  logic [1:0] sw_route;
  logic [NGEN-1:0] byp_mask, peer_out;
  logic ctl_asserted;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pwm_ctl_gate #(.NGEN(NGEN), .SELF_IDX(0)) dut (
    .clk(clk), .rst(rst), .ctl_in(ctl_in), .duty_act(duty_act),
    .blank_act(blank_act), .pg_trig(pg_trig), .ext_src(ext_src),
    .trig_evt(trig_evt), .eoc(eoc), .acc_mode(acc_mode),
    .latch_rst_dom(latch_rst_dom), .term_sel(term_sel), .term_inv(term_inv),
    .term_sync_dis(term_sync_dis), .in_sync(in_sync), .in_inv(in_inv),
    .aq_src(aq_src), .aq_inv(aq_inv), .tq_src(tq_src), .tq_inv(tq_inv),
    .sw_level(sw_level), .sw_route(sw_route), .sw_term_pulse(sw_term_pulse),
    .byp_en(byp_en), .byp_mask(byp_mask), .peer_out(peer_out),
    .ctl_asserted(ctl_asserted)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic exp);
    n_vec++;
    if (ctl_asserted !== exp) begin
      n_bad++;
      $display("FAIL %s: ctl_asserted=%b expected %b", tag, ctl_asserted, exp);
    end
  endtask

  task automatic defaults();
    ctl_in = 0; duty_act = 0; blank_act = 0; pg_trig = 0; eoc = 0;
    ext_src = 0; trig_evt = 0; acc_mode = 0; term_sel = 0; aq_src = 0;
    tq_src = 0; latch_rst_dom = 0; term_inv = 0; term_sync_dis = 1;
    in_sync = 0; in_inv = 0; aq_inv = 0; tq_inv = 0; sw_level = 0;
    sw_term_pulse = 0; byp_en = 0; sw_route = 2'b11; byp_mask = 0; peer_out = 0;
  endtask

  task automatic restart();
    rst = 1; defaults(); tick(); tick(); rst = 0;
  endtask

  task automatic t_reset();
    rst = 1; defaults(); tick(); tick();
    chk("R1 during reset", 0);
    rst = 0; tick(); chk("R1 after release", 0);
    acc_mode = 3'b011; ctl_in = 1; tick(); chk("R1 latch set", 1);
    ctl_in = 0; rst = 1; tick(); chk("R1 reset output", 0);
    rst = 0; tick(); chk("R1 latch cleared", 0);
  endtask

  task automatic t_level();
    restart();
    ctl_in = 1; tick(); chk("R2 level high", 1);
    ctl_in = 0; tick(); chk("R2 level low", 0);
    in_inv = 1; tick(); chk("R2 inverted low", 1);
    ctl_in = 1; tick(); chk("R2 inverted high", 0);
  endtask

  task automatic t_aqual();
    restart();
    ctl_in = 1; aq_src = 3'b001; duty_act = 0; tick(); chk("R11 duty qual low", 0);
    duty_act = 1; tick(); chk("R11 duty qual high", 1);
    aq_inv = 1; tick(); chk("R11 qual inverted", 0);
    aq_src = 3'b111; aq_inv = 0; tick(); chk("R11 soft forced 0", 0);
    aq_src = 3'b000; aq_inv = 1; tick(); chk("R11 forced 1 ignores inv", 1);
    aq_src = 3'b100; aq_inv = 0; ext_src = 3'b001; tick(); chk("R11 ext0", 1);
    ext_src = 3'b010; tick(); chk("R11 ext0 low", 0);
  endtask

  task automatic t_swroute();
    restart();
    sw_route = 2'b00; sw_level = 1; tick(); chk("R12 soft into input", 1);
    sw_route = 2'b01; aq_src = 3'b111; ctl_in = 1; tick(); chk("R12 soft into AQ", 1);
    sw_level = 0; tick(); chk("R12 soft AQ low", 0);
    sw_route = 2'b11; sw_level = 1; tick(); chk("R12 route none", 0);
    aq_src = 3'b000; ctl_in = 0; sw_route = 2'b10; tick(); chk("R12 TQ route not input", 0);
  endtask

  task automatic t_edge();
    restart();
    acc_mode = 3'b001; tick();
    ctl_in = 1; tick(); chk("R3 rise pulse", 1);
    tick(); chk("R3 rise one cycle", 0);
    ctl_in = 0; tick(); chk("R3 no pulse on fall", 0);
    ctl_in = 1; tick(); tick();
    acc_mode = 3'b010; ctl_in = 0; tick(); chk("R3 any edge fall", 1);
    tick(); chk("R3 any edge one cycle", 0);
    ctl_in = 1; tick(); chk("R3 any edge rise", 1);
  endtask

  task automatic t_latch();
    restart();
    acc_mode = 3'b011; term_sel = 3'b010;
    ctl_in = 1; tick(); chk("R4 latched set", 1);
    ctl_in = 0; tick(); chk("R4 latched hold", 1);
    tick(); chk("R4 latched hold 2", 1);
    trig_evt = 3'b010; tick(); chk("R7 wrong trigger ignored", 1);
    trig_evt = 3'b001; tick(); chk("R7 trigger A clears", 0);
    trig_evt = 0; tick(); chk("R4 stays clear", 0);
    restart();
    acc_mode = 3'b100; term_sel = 3'b010;
    ctl_in = 1; tick(); chk("R4 latched rising set", 1);
    trig_evt = 3'b001; tick(); chk("R4 rising latch cleared", 0);
    trig_evt = 0; tick(); chk("R4 held level no reset", 0);
    ctl_in = 0; tick(); ctl_in = 1; tick(); chk("R4 new rise sets", 1);
  endtask

  task automatic t_term();
    restart();
    acc_mode = 3'b011; term_sel = 3'b000;
    ctl_in = 1; tick(); ctl_in = 0; tick(); chk("R7 hold before sw", 1);
    sw_term_pulse = 1; tick(); chk("R7 software clear", 0);
    sw_term_pulse = 0;
    term_sel = 3'b001; ctl_in = 1; tick(); chk("R7 auto set", 1);
    ctl_in = 0; tick(); chk("R7 auto clear on fall", 0);
    term_sel = 3'b101; term_inv = 1; ext_src = 3'b001;
    ctl_in = 1; tick(); chk("R7 ext set", 1);
    ctl_in = 0; tick(); chk("R7 ext inverted inactive", 1);
    ext_src = 3'b000; tick(); chk("R7 ext inverted clears", 0);
    term_sel = 3'b010;
    ctl_in = 1; tick(); ctl_in = 0; tick(); chk("R7 inv not on trigger", 1);
    term_sel = 3'b111; term_inv = 0; tick(); chk("R7 ext2 idle", 1);
    ext_src = 3'b100; tick(); chk("R7 ext2 clears", 0);
  endtask

  task automatic t_dominance();
    restart();
    acc_mode = 3'b011; term_sel = 3'b010;
    ctl_in = 1; trig_evt = 3'b001; latch_rst_dom = 0; tick(); chk("R6 set dominant", 1);
    latch_rst_dom = 1; tick(); chk("R6 reset dominant", 0);
    trig_evt = 0; tick(); chk("R6 set after release", 1);
  endtask

  task automatic t_tqual();
    restart();
    acc_mode = 3'b011; term_sel = 3'b010; tq_src = 3'b001; duty_act = 0;
    ctl_in = 1; tick(); ctl_in = 0; trig_evt = 3'b001; tick(); chk("R8 blocked by TQ", 1);
    duty_act = 1; tick(); chk("R8 TQ high clears", 0);
    trig_evt = 0; tq_src = 3'b000; tq_inv = 1;
    ctl_in = 1; tick(); ctl_in = 0; trig_evt = 3'b001; tick(); chk("R8 forced TQ ignores inv", 0);
    trig_evt = 0; tq_src = 3'b001; tq_inv = 1; duty_act = 1;
    ctl_in = 1; tick(); ctl_in = 0; trig_evt = 3'b001; tick(); chk("R8 TQ inverted blocks", 1);
    tq_inv = 0; duty_act = 0; sw_route = 2'b10; sw_level = 1; tick(); chk("R12 soft into TQ clears", 0);
  endtask

  task automatic t_sync();
    restart();
    acc_mode = 3'b011; term_sel = 3'b010; term_sync_dis = 0;
    ctl_in = 1; tick(); chk("R9 set", 1);
    ctl_in = 0; trig_evt = 3'b001; tick(); chk("R9 deferred", 1);
    trig_evt = 0; tick(); chk("R9 pending hold", 1);
    eoc = 1; tick(); chk("R9 clear at end of cycle", 0);
    eoc = 0; tick(); chk("R9 stays clear", 0);
  endtask

  task automatic t_insync();
    restart();
    in_sync = 1; ctl_in = 1; tick(); chk("R10 not sampled yet", 0);
    tick(); chk("R10 still not sampled", 0);
    eoc = 1; tick(); chk("R10 sample edge", 0);
    eoc = 0; tick(); chk("R10 sampled high", 1);
    ctl_in = 0; tick(); chk("R10 held between strobes", 1);
    eoc = 1; tick(); chk("R10 old value at strobe", 1);
    eoc = 0; tick(); chk("R10 sampled low", 0);
  endtask

  task automatic t_swap();
    restart();
    acc_mode = 3'b110; aq_src = 3'b001; term_sel = 3'b010; ctl_in = 1; duty_act = 0;
    tick(); chk("R5 idle", 0);
    duty_act = 1; tick(); chk("R5 qualifier edge sets", 1);
    duty_act = 0; tick(); chk("R5 latched", 1);
    ctl_in = 0; tick(); chk("R5 input gates", 0);
    ctl_in = 1; tick(); chk("R5 gate reopened", 1);
    trig_evt = 3'b001; tick(); chk("R5 cleared", 0);
    trig_evt = 0; ctl_in = 0; tick(); ctl_in = 1; tick(); chk("R5 input edge no set", 0);
    acc_mode = 3'b111; duty_act = 1; tick(); chk("R5 swapped any rise", 1);
    trig_evt = 3'b001; tick(); trig_evt = 0;
    duty_act = 0; tick(); chk("R5 swapped any fall", 1);
  endtask

  task automatic t_bypass();
    restart();
    ctl_in = 1; byp_en = 1; peer_out = 8'h01; byp_mask = 8'h01; tick(); chk("R13 self excluded", 0);
    peer_out = 8'h04; byp_mask = 8'h06; tick(); chk("R13 peer selected", 1);
    peer_out = 8'h08; tick(); chk("R13 peer unmasked", 0);
    peer_out = 8'h0C; byp_mask = 8'hFF; tick(); chk("R13 OR of peers", 1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    defaults();
    rst = 1;
    t_reset();
    t_level();
    t_aqual();
    t_swroute();
    t_edge();
    t_latch();
    t_term();
    t_dominance();
    t_tqual();
    t_sync();
    t_insync();
    t_swap();
    t_bypass();
    summary();
    $finish;
  end
endmodule